// File: doc/BRIEF.md
# Relative Deadline Delta Queue

This block keeps a sorted list of timed entries, such as task deadlines for an earliest-deadline scheduler. Each entry stores only the amount by which its key exceeds the key of the entry in front of it. The head entry therefore holds the time left from now. A periodic tick only has to touch the head, and no stored value ever has to represent an absolute time that grows without bound.

A client inserts an entry by giving a task id and a key relative to the current time. The block walks the list one position per cycle to find where the entry belongs, then places it. It repairs the delta of the entry behind it so that the keys of later entries do not change. A client removes an entry by task id. The removed entry's delta is folded into its successor. The block always presents the head task and its remaining time, and it raises an expiry flag once that remaining time reaches zero.

Ticks that arrive while a walk is running are counted and applied to the head after the walk ends.

Top module: `delta_queue`

## Requirements
- R1: After reset the queue reports empty=1, full=0, busy=0 and expired=0.
- R2: With the queue idle, headId names the entry with the smallest key, and headRemain equals that key less the ticks applied since it was inserted.
- R3: Among entries whose keys are equal, the entry inserted earlier stays closer to the head.
- R4: Inserting or removing an entry leaves the remaining time of every other entry unchanged. After the head is removed, the new head shows its own full remaining time.
- R5: A remove request deletes only the entry with the matching id, wherever it sits in the list. A remove request for an id that is not present leaves the queue unchanged.
- R6: Each applied tick lowers the head's remaining time by one and stops at zero. expired is 1 exactly when the queue is non-empty and headRemain is 0, and headId then names the expiring task.
- R7: An accepted insert that lands at position p (head is 0) holds busy high for p+1 cycles. An accepted remove holds busy high for one cycle per entry it inspects. Requests that arrive while busy is high are ignored. Insert wins over remove when both are requested in the same cycle.
- R8: full=1 when DEPTH entries are held. An insert request while full is ignored: busy stays low and the head does not change.
- R9: Ticks that arrive while busy is high do not change the head during the walk. They are applied afterwards, at most one pending tick per idle cycle on top of any new tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insReq | input | 1 | Insert request, sampled when idle |
| insId | input | ID_W | Task id of the entry to insert |
| insKey | input | KEY_W | Key of the new entry, relative to now |
| remReq | input | 1 | Remove request, sampled when idle |
| remId | input | ID_W | Task id to remove |
| tick | input | 1 | One time unit has elapsed |
| busy | output | 1 | An insert or remove walk is running |
| empty | output | 1 | No entries held |
| full | output | 1 | DEPTH entries held |
| headId | output | ID_W | Task id at the head |
| headRemain | output | KEY_W | Time left for the head entry |
| expired | output | 1 | The head's remaining time is zero |

## Verification
The bound checker watches several properties on every cycle. An idle queue with no request stays idle. The head does not move while a walk runs, even when ticks arrive. A zero head stays at zero and keeps expired high. A tick lowers the head, and an insert into a full queue is refused. The orderings can only be shown by the bench's scenarios: tie order, the keys of later entries being preserved across insertion and middle removal, and the exact walk lengths. The bench drains the queue and compares each head with a sorted reference model.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_INS, ST_REM} dqState_t;

  typedef struct packed {
    logic       place;
    logic       drop;
    logic [1:0] tickAmt;
  } dqStrobe_t;
endpackage

// File: rtl/dq_store.sv
module dq_store
  import dq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 4,
  parameter int KEY_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dqStrobe_t        strobe,
  input  logic [CNT_W-1:0] pos,
  input  logic [ID_W-1:0]  newId,
  input  logic [KEY_W-1:0] newKey,
  input  logic [CNT_W-1:0] readIdx,
  output logic [ID_W-1:0]  curId,
  output logic [KEY_W-1:0] curDelta,
  output logic [CNT_W-1:0] count,
  output logic [ID_W-1:0]  headId,
  output logic [KEY_W-1:0] headDelta
);
  logic [ID_W-1:0]  entId    [DEPTH];
  logic [KEY_W-1:0] entDelta [DEPTH];
  logic [ID_W-1:0]  nxtId    [DEPTH];
  logic [KEY_W-1:0] nxtDelta [DEPTH];
  logic [CNT_W-1:0] nxtCount;

  always_comb begin
    nxtId    = entId;
    nxtDelta = entDelta;
    nxtCount = count;
    if (strobe.place) begin
      for (int i = 1; i < DEPTH; i++) begin
        if (i > int'(pos)) begin
          nxtId[i]    = entId[i-1];
          nxtDelta[i] = entDelta[i-1];
        end
        if (i == int'(pos) + 1 && pos < count)
          nxtDelta[i] = entDelta[i-1] - newKey;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (i == int'(pos)) begin
          nxtId[i]    = newId;
          nxtDelta[i] = newKey;
        end
      end
      nxtCount = count + 1'b1;
    end else if (strobe.drop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(pos)) begin
          nxtId[i]    = entId[i+1];
          nxtDelta[i] = entDelta[i+1];
        end
        if (i == int'(pos) && i + 1 < int'(count))
          nxtDelta[i] = entDelta[i+1] + entDelta[i];
      end
      nxtCount = count - 1'b1;
    end else if (strobe.tickAmt != 2'd0 && count != '0) begin
      nxtDelta[0] = (entDelta[0] > KEY_W'(strobe.tickAmt)) ?
                    entDelta[0] - KEY_W'(strobe.tickAmt) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entId[i]    <= '0;
        entDelta[i] <= '0;
      end
    end else begin
      count    <= nxtCount;
      entId    <= nxtId;
      entDelta <= nxtDelta;
    end
  end

  always_comb begin
    curId    = '0;
    curDelta = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(readIdx) == i) begin
        curId    = entId[i];
        curDelta = entDelta[i];
      end
    end
  end

  assign headId    = entId[0];
  assign headDelta = entDelta[0];
endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4,
  parameter int KEY_W  = 16,
  parameter int PEND_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insReq,
  input  logic [ID_W-1:0]  insId,
  input  logic [KEY_W-1:0] insKey,
  input  logic             remReq,
  input  logic [ID_W-1:0]  remId,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [ID_W-1:0]  curId,
  input  logic [KEY_W-1:0] curDelta,
  output dqStrobe_t        strobe,
  output logic [CNT_W-1:0] pos,
  output logic [ID_W-1:0]  newId,
  output logic [KEY_W-1:0] newKey,
  output logic [CNT_W-1:0] readIdx,
  output logic             busy
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  dqState_t         state;
  logic [CNT_W-1:0] idx;
  logic [KEY_W-1:0] rem;
  logic [ID_W-1:0]  tgtId;
  logic [PEND_W-1:0] pend;
  logic             atEnd;

  assign atEnd   = (idx == count);
  assign readIdx = idx;
  assign pos     = idx;
  assign newId   = tgtId;
  assign newKey  = rem;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: strobe.tickAmt = {1'b0, tick} + {1'b0, pend != '0};
      ST_INS:  strobe.place = atEnd || (rem < curDelta);
      ST_REM:  strobe.drop  = !atEnd && (curId == tgtId);
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      rem   <= '0;
      tgtId <= '0;
      pend  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (pend != '0) pend <= pend - 1'b1;
          if (insReq && count != CNT_W'(DEPTH)) begin
            state <= ST_INS;
            rem   <= insKey;
            tgtId <= insId;
          end else if (remReq) begin
            state <= ST_REM;
            tgtId <= remId;
          end
        end
        ST_INS: begin
          if (tick && pend != PEND_MAX) pend <= pend + 1'b1;
          if (strobe.place) state <= ST_IDLE;
          else begin
            rem <= rem - curDelta;
            idx <= idx + 1'b1;
          end
        end
        ST_REM: begin
          if (tick && pend != PEND_MAX) pend <= pend + 1'b1;
          if (atEnd || strobe.drop) state <= ST_IDLE;
          else idx <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/delta_queue.sv
module delta_queue
  import dq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4,
  parameter int KEY_W  = 16,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insReq,
  input  logic [ID_W-1:0]  insId,
  input  logic [KEY_W-1:0] insKey,
  input  logic             remReq,
  input  logic [ID_W-1:0]  remId,
  input  logic             tick,
  output logic             busy,
  output logic             empty,
  output logic             full,
  output logic [ID_W-1:0]  headId,
  output logic [KEY_W-1:0] headRemain,
  output logic             expired
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  dqStrobe_t        strobe;
  logic [CNT_W-1:0] pos, readIdx, count;
  logic [ID_W-1:0]  newId, curId;
  logic [KEY_W-1:0] newKey, curDelta;

  dq_ctrl #(.DEPTH(DEPTH), .ID_W(ID_W), .KEY_W(KEY_W), .PEND_W(PEND_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .insReq(insReq), .insId(insId), .insKey(insKey),
    .remReq(remReq), .remId(remId), .tick(tick), .count(count),
    .curId(curId), .curDelta(curDelta), .strobe(strobe), .pos(pos),
    .newId(newId), .newKey(newKey), .readIdx(readIdx), .busy(busy)
  );

  dq_store #(.DEPTH(DEPTH), .ID_W(ID_W), .KEY_W(KEY_W)) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pos(pos), .newId(newId),
    .newKey(newKey), .readIdx(readIdx), .curId(curId), .curDelta(curDelta),
    .count(count), .headId(headId), .headDelta(headRemain)
  );

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign expired = !empty && (headRemain == '0);
endmodule

// File: rtl/delta_queue_checker.sv
module delta_queue_checker #(
  parameter int ID_W  = 4,
  parameter int KEY_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             insReq,
  input logic             remReq,
  input logic             tick,
  input logic             busy,
  input logic             empty,
  input logic             full,
  input logic [ID_W-1:0]  headId,
  input logic [KEY_W-1:0] headRemain,
  input logic             expired
);
  logic pastOk;
  always_ff @(posedge clk) pastOk <= rstN;

  p_idle_stays_r7: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !busy && !insReq && !remReq |=> !busy);

  p_full_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !busy && full && insReq && !remReq |=> !busy && full && $stable(headId));

  p_hold_walk_r9: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && busy && $past(busy) |-> $stable(headRemain) && $stable(headId));

  p_zero_sticks_r6: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !busy && !empty && headRemain == '0 && !insReq && !remReq
    |=> headRemain == '0 && $stable(headId) && expired);

  p_tick_lowers_r6: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !busy && !empty && tick && headRemain > KEY_W'(2) && !insReq && !remReq
    |=> headRemain < $past(headRemain));
endmodule

bind delta_queue delta_queue_checker #(.ID_W(ID_W), .KEY_W(KEY_W)) chk_i (
  .clk(clk), .rstN(rstN), .insReq(insReq), .remReq(remReq), .tick(tick),
  .busy(busy), .empty(empty), .full(full), .headId(headId),
  .headRemain(headRemain), .expired(expired)
);

// File: tb/delta_queue_tb_top.sv
`timescale 1ns/1ps
module delta_queue_tb_top;
  localparam int DEPTH = 8;
  localparam int ID_W  = 4;
  localparam int KEY_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insReq = 1'b0, remReq = 1'b0, tick = 1'b0;
  logic [ID_W-1:0]  insId = '0, remId = '0;
  logic [KEY_W-1:0] insKey = '0;
  logic busy, empty, full, expired;
  logic [ID_W-1:0]  headId;
  logic [KEY_W-1:0] headRemain;

  always #2.5 clk = ~clk;

  delta_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .KEY_W(KEY_W)) dut_i (
    .clk(clk), .rstN(rstN), .insReq(insReq), .insId(insId), .insKey(insKey),
    .remReq(remReq), .remId(remId), .tick(tick), .busy(busy), .empty(empty),
    .full(full), .headId(headId), .headRemain(headRemain), .expired(expired)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model: ids and remaining keys, sorted
  int mId[$];
  int mKey[$];

  typedef struct { int id; int rem; string tag; } exp_t;
  exp_t expQ[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk(int'(headId) == e.id, {e.tag, " headId"}, int'(headId), e.id);
      chk(int'(headRemain) == e.rem, {e.tag, " headRemain"}, int'(headRemain), e.rem);
    end
  end

  task automatic expectHead(input string tag);
    exp_t e;
    e.id = mId[0]; e.rem = mKey[0]; e.tag = tag;
    expQ.push_back(e);
    wait (expQ.size() == 0);
  endtask

  function automatic void modelIns(input int id, input int key);
    int p = mKey.size();
    for (int j = 0; j < mKey.size(); j++)
      if (mKey[j] > key) begin p = j; break; end
    mId.insert(p, id);
    mKey.insert(p, key);
  endfunction

  function automatic void modelRem(input int id);
    for (int j = 0; j < mId.size(); j++)
      if (mId[j] == id) begin mId.delete(j); mKey.delete(j); break; end
  endfunction

  function automatic void modelTick();
    if (mKey.size() != 0 && mKey[0] > 0)
      for (int j = 0; j < mKey.size(); j++) mKey[j]--;
  endfunction

  task automatic doIns(input int id, input int key, output int n);
    @(negedge clk);
    insReq = 1; insId = ID_W'(id); insKey = KEY_W'(key);
    @(negedge clk);
    insReq = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic doRem(input int id, output int n);
    @(negedge clk);
    remReq = 1; remId = ID_W'(id);
    @(negedge clk);
    remReq = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic doTick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    modelTick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(empty == 1 && full == 0 && busy == 0 && expired == 0, "R1 reset flags",
        {empty, full, busy, expired}, 4'b1000);

    // R2/R3/R7: ordered insertion and walk lengths
    doIns(1, 20, n); modelIns(1, 20); chk(n == 1, "R7 insert into empty cycles", n, 1);
    doIns(2, 5, n);  modelIns(2, 5);  chk(n == 1, "R7 insert at head cycles", n, 1);
    doIns(3, 12, n); modelIns(3, 12); chk(n == 2, "R7 insert at pos1 cycles", n, 2);
    doIns(4, 12, n); modelIns(4, 12); chk(n == 3, "R3 tie placed behind cycles", n, 3);
    doIns(5, 30, n); modelIns(5, 30); chk(n == 5, "R7 insert at tail cycles", n, 5);
    expectHead("R2 smallest key at head");

    // R7: request while busy is ignored
    @(negedge clk);
    insReq = 1; insId = 6; insKey = 50;
    @(negedge clk);
    insReq = 0; remReq = 1; remId = 2;
    @(negedge clk);
    remReq = 0;
    while (busy) @(negedge clk);
    modelIns(6, 50);
    expectHead("R7 remove during walk ignored");

    // R3/R4: drain head, ties keep order
    doRem(2, n); modelRem(2); chk(n == 1, "R7 head remove cycles", n, 1);
    expectHead("R3 earlier tie first");
    doRem(3, n); modelRem(3);
    expectHead("R4 tie successor keeps key");

    // R5: middle removal and absent id
    doRem(5, n); modelRem(5); chk(n == 3, "R5 middle remove cycles", n, 3);
    expectHead("R5 head after middle remove");
    doRem(4, n); modelRem(4);
    expectHead("R4 key after head remove");
    doRem(1, n); modelRem(1);
    expectHead("R5 key past removed middle");
    doRem(9, n); chk(n == 2, "R5 absent id walk cycles", n, 2);
    expectHead("R5 absent id no change");
    doRem(6, n); modelRem(6);
    chk(empty == 1, "R5 queue empty after drain", empty, 1);

    // R6: ticks, saturation, expiry
    doIns(7, 3, n); modelIns(7, 3);
    doIns(8, 5, n); modelIns(8, 5);
    doTick(); doTick();
    expectHead("R6 tick lowers head");
    chk(expired == 0, "R6 not expired at 1", expired, 0);
    doTick();
    expectHead("R6 head reaches zero");
    chk(expired == 1, "R6 expired at zero", expired, 1);
    doTick(); doTick();
    expectHead("R6 saturates at zero");
    doRem(7, n); modelRem(7);
    expectHead("R6 successor remaining time");
    chk(expired == 0, "R6 expired clears", expired, 0);
    doRem(8, n); modelRem(8);

    // R8: full
    for (int k = 0; k < DEPTH; k++) begin
      doIns(k, 100 + 3 * k, n); modelIns(k, 100 + 3 * k);
    end
    chk(full == 1, "R8 full flag", full, 1);
    doIns(9, 1, n);
    chk(n == 0, "R8 insert while full ignored", n, 0);
    chk(full == 1, "R8 still full", full, 1);
    expectHead("R8 head unchanged when full");
    for (int k = 0; k < DEPTH; k++) begin
      doRem(mId[0], n); modelRem(mId[0]);
      if (mId.size() != 0) expectHead("R4 drain from full");
    end
    chk(empty == 1, "R8 drained", empty, 1);

    // R9: ticks during a walk are deferred
    doIns(1, 10, n); modelIns(1, 10);
    doIns(2, 20, n); modelIns(2, 20);
    @(negedge clk);
    insReq = 1; insId = 3; insKey = 25;
    @(negedge clk);
    insReq = 0; tick = 1;
    chk(busy == 1, "R9 walk running", busy, 1);
    @(negedge clk);
    chk(int'(headRemain) == 10, "R9 head held during walk", int'(headRemain), 10);
    @(negedge clk);
    tick = 0;
    while (busy) @(negedge clk);
    modelIns(3, 25); modelTick(); modelTick();
    repeat (3) @(negedge clk);
    expectHead("R9 deferred ticks applied");
    doRem(1, n); modelRem(1);
    expectHead("R9 successor shifted by ticks");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule